// File: doc/BRIEF.md
# Sync-Interval Stream Monitor

This block watches a sample stream in which every valid sample carries a 64-bit running sequence number. The stream also carries a periodic sync marker and a start-of-block marker. Each valid sync sample ends one sync interval and starts the next. On that sample the block stores the sequence number. On the same cycle it copies the number of blocks and the number of valid samples seen during the interval that just ended into holding registers. The running counters then restart.

Software reads the stored values through a small read-only port. The sequence number is replaced by all ones (the value -1) whenever it cannot be trusted. That happens when processing is switched off, or when the sync markers stop arriving or arrive too far apart. A gap like that means the data clock is or was faulty. A programmable cycle limit sets the largest allowed spacing between syncs; about 1.5 times the nominal interval is a typical setting. Once the all-ones value is showing, only two successive, properly spaced syncs bring the real number back.

Top module: `sync_stream_monitor`

## Requirements
- R1: On a cycle with `in_valid` and `in_sync` both high, `in_seq` is stored. When no fault is present it reads back at address 0 (bits 31:0) and address 1 (bits 63:32).
- R2: Address 2 returns the block count of the last finished interval. It counts cycles with `in_valid` and `in_sob` high, from one sync sample (included) to the next sync sample (excluded).
- R3: Address 3 returns the number of cycles with `in_valid` high over the same span as R2. Both running counts restart on the sync sample and are copied on that same cycle.
- R4: If `proc_en` is low at any clock edge, the fault state is set at that edge, and addresses 0 and 1 then read all ones.
- R5: Let L be `wd_limit` and let a sync be accepted at edge t. Another sync at or before edge t+L keeps the fault clear. At edge t+L+1 the fault is set, whether or not a sync arrives on that cycle.
- R6: A set fault clears only on the second of two successive syncs. Both must see `proc_en` high, and the spacing must cause no fault condition in between. A lone sync leaves all ones showing, and the second sync's number becomes readable at once.
- R7: After reset the fault is set (addresses 0 and 1 read all ones), addresses 2 and 3 read 0, and `rd_valid` is low.
- R8: `rd_data` and `rd_valid` are registered. They appear one cycle after `rd_en` is sampled high, and `rd_valid` is low in every other cycle. Addresses 4 to 7 read 0.
- R9: Cycles with `in_valid` low are ignored. `in_sync` or `in_sob` on such cycles changes no count, no stored number and no fault state.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Data path clock |
| rst_n | input | 1 | Active-low synchronous reset |
| proc_en | input | 1 | Processing enable level |
| in_valid | input | 1 | Sample valid |
| in_sync | input | 1 | Sync marker on this sample |
| in_sob | input | 1 | Start-of-block marker on this sample |
| in_seq | input | 64 | Sequence number of this sample |
| wd_limit | input | WD_W | Largest allowed sync spacing in cycles |
| rd_en | input | 1 | Read request |
| rd_addr | input | 3 | Read word address |
| rd_data | output | DATA_W | Read data, one cycle after request |
| rd_valid | output | 1 | Read data valid |

## Verification
Every stored value and every fault change takes effect at the clock edge that samples the sync, or the edge that samples `proc_en` low. A read issued in the next cycle returns it one edge later. The bench drives each input for exactly one edge and reads at the following edge, so each register is sampled at the negative edge after the read edge. The watchdog boundary is counted in edges from the accepted sync. The read at edge t+L+1 must still show the number, and the read at edge t+L+2 must show all ones.

// File: rtl/sync_stream_monitor.sv
module sync_stream_monitor #(
  parameter int DATA_W = 32,
  parameter int WD_W   = 32
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              proc_en,
  input  logic              in_valid,
  input  logic              in_sync,
  input  logic              in_sob,
  input  logic [63:0]       in_seq,
  input  logic [WD_W-1:0]   wd_limit,
  input  logic              rd_en,
  input  logic [2:0]        rd_addr,
  output logic [DATA_W-1:0] rd_data,
  output logic              rd_valid
);
  localparam int SEQ_W = 64;

  logic              sync_ev, sob_ev, bad;
  logic [DATA_W-1:0] smp_cnt, blk_cnt, smp_hold, blk_hold;
  logic [SEQ_W-1:0]  seq_hold, seq_rep;
  logic [WD_W-1:0]   wd_cnt;
  logic              fault, armed;
  logic [DATA_W-1:0] rd_mux;

  assign sync_ev = in_valid & in_sync;
  assign sob_ev  = in_valid & in_sob;
  assign bad     = !proc_en || (wd_cnt >= wd_limit);
  assign seq_rep = fault ? {SEQ_W{1'b1}} : seq_hold;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      smp_cnt  <= '0;
      blk_cnt  <= '0;
      smp_hold <= '0;
      blk_hold <= '0;
      seq_hold <= '0;
    end else if (sync_ev) begin
      smp_hold <= smp_cnt;
      blk_hold <= blk_cnt;
      seq_hold <= in_seq;
      smp_cnt  <= DATA_W'(1);
      blk_cnt  <= DATA_W'(in_sob);
    end else begin
      if (in_valid && smp_cnt != '1) smp_cnt <= smp_cnt + 1'b1;
      if (sob_ev && blk_cnt != '1)   blk_cnt <= blk_cnt + 1'b1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)              wd_cnt <= '0;
    else if (sync_ev)        wd_cnt <= '0;
    else if (wd_cnt != '1)   wd_cnt <= wd_cnt + 1'b1;
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      fault <= 1'b1;
      armed <= 1'b0;
    end else if (bad) begin
      fault <= 1'b1;
      armed <= proc_en && sync_ev;
    end else if (sync_ev) begin
      if (armed) fault <= 1'b0;
      armed <= 1'b1;
    end
  end

  always_comb begin
    case (rd_addr)
      3'd0:    rd_mux = seq_rep[DATA_W-1:0];
      3'd1:    rd_mux = seq_rep[SEQ_W-1:SEQ_W-DATA_W];
      3'd2:    rd_mux = blk_hold;
      3'd3:    rd_mux = smp_hold;
      default: rd_mux = '0;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      rd_data  <= '0;
      rd_valid <= 1'b0;
    end else begin
      rd_valid <= rd_en;
      if (rd_en) rd_data <= rd_mux;
    end
  end

  // R3
  smp_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
    sync_ev |=> smp_cnt == DATA_W'(1));

  // R4
  proc_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !proc_en |=> fault);

  // R5
  wd_expire_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (wd_cnt >= wd_limit) |=> fault);

  // R6
  clear_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(fault) |-> ($past(sync_ev) && $past(armed) && $past(proc_en)));

  // R8
  rd_valid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    rd_en |=> rd_valid);

  // R8
  rd_idle_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !rd_en |=> !rd_valid);

  // R9
  ignore_invalid_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !in_valid |=> ($stable(smp_cnt) && $stable(blk_cnt) && $stable(seq_hold)));
endmodule

// File: tb/test_sync_stream_monitor.sv
module test_sync_stream_monitor;
  localparam int NV = 5;
  localparam int V_LEN[NV] = '{40, 37, 64, 25, 50};
  localparam int V_PER[NV] = '{8, 5, 1, 25, 7};
  localparam logic [63:0] V_SEQ[NV] = '{
    64'h0000_0000_0000_0010, 64'h1234_5678_9abc_def0, 64'h0000_0001_0000_0000,
    64'hffff_ffff_0000_0001, 64'h8000_0000_7fff_ff00};
  localparam logic [31:0] ONES = 32'hffff_ffff;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        proc_en = 1'b1;
  logic        in_valid = 1'b0, in_sync = 1'b0, in_sob = 1'b0;
  logic [63:0] in_seq = '0;
  logic [31:0] wd_limit = 32'd500;
  logic        rd_en = 1'b0;
  logic [2:0]  rd_addr = '0;
  logic [31:0] rd_data;
  logic        rd_valid;

  int checks = 0, errors = 0;
  bit done = 1'b0;

  sync_stream_monitor i_sync_stream_monitor (
    .clk(clk), .rst_n(rst_n), .proc_en(proc_en), .in_valid(in_valid),
    .in_sync(in_sync), .in_sob(in_sob), .in_seq(in_seq), .wd_limit(wd_limit),
    .rd_en(rd_en), .rd_addr(rd_addr), .rd_data(rd_data), .rd_valid(rd_valid));

  always #2 clk = ~clk;

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic drive(input logic v, input logic s, input logic b, input logic [63:0] q);
    in_valid = v; in_sync = s; in_sob = b; in_seq = q; rd_en = 1'b0;
    @(negedge clk);
  endtask

  task automatic idle(input int n);
    for (int k = 0; k < n; k++) drive(1'b0, 1'b0, 1'b0, '0);
  endtask

  task automatic rd(input logic [2:0] a, output logic [31:0] d, output logic v);
    in_valid = 1'b0; in_sync = 1'b0; in_sob = 1'b0;
    rd_en = 1'b1; rd_addr = a;
    @(negedge clk);
    rd_en = 1'b0;
    d = rd_data; v = rd_valid;
  endtask

  function automatic logic [31:0] nblk(input int i);
    return 32'((V_LEN[i] - 1) / V_PER[i] + 1);
  endfunction

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: actual hung expected finish");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    logic [31:0] d;
    logic v;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;

    // R7 reset state
    chk("R7 rd_valid", {31'd0, rd_valid}, 32'd0);
    rd(3'd0, d, v); chk("R7 seq lo", d, ONES);
    rd(3'd1, d, v); chk("R7 seq hi", d, ONES);
    rd(3'd2, d, v); chk("R7 blocks", d, 32'd0);
    rd(3'd3, d, v); chk("R7 samples", d, 32'd0);

    // R8 unmapped address and read valid timing
    rd(3'd5, d, v); chk("R8 unmapped", d, 32'd0);
    chk("R8 rd_valid high", {31'd0, v}, 32'd1);
    idle(1);
    chk("R8 rd_valid low", {31'd0, rd_valid}, 32'd0);

    // Vector table: R1 R2 R3, glitches on invalid cycles test R9
    for (int i = 0; i < NV; i++) begin
      drive(1'b1, 1'b1, 1'b1, V_SEQ[i]);
      rd(3'd0, d, v); chk(i == 0 ? "R6 lone sync lo" : "R1 seq lo", d, i == 0 ? ONES : V_SEQ[i][31:0]);
      rd(3'd1, d, v); chk(i == 0 ? "R6 lone sync hi" : "R1 seq hi", d, i == 0 ? ONES : V_SEQ[i][63:32]);
      rd(3'd2, d, v); chk("R2 R9 blocks", d, i == 0 ? 32'd0 : nblk(i - 1));
      rd(3'd3, d, v); chk("R3 R9 samples", d, i == 0 ? 32'd0 : 32'(V_LEN[i - 1]));
      for (int j = 1; j < V_LEN[i]; j++) begin
        drive(1'b1, 1'b0, (j % V_PER[i]) == 0, V_SEQ[i] + 64'(j));
        if (j % 5 == 4) drive(1'b0, 1'b1, 1'b1, '1);
      end
    end
    drive(1'b1, 1'b1, 1'b0, 64'h0bad_cafe_0000_0042);
    rd(3'd0, d, v); chk("R1 final seq lo", d, 32'h0000_0042);
    rd(3'd1, d, v); chk("R1 final seq hi", d, 32'h0bad_cafe);
    rd(3'd2, d, v); chk("R2 final blocks", d, nblk(NV - 1));
    rd(3'd3, d, v); chk("R3 final samples", d, 32'(V_LEN[NV - 1]));

    // R3 interval where the sync sample has no block start
    idle(2);
    drive(1'b1, 1'b1, 1'b0, 64'h77);
    rd(3'd2, d, v); chk("R2 no-sob sync blocks", d, 32'd0);
    rd(3'd3, d, v); chk("R3 one sample interval", d, 32'd1);

    // R5 watchdog boundary with L = 20
    drive(1'b1, 1'b1, 1'b1, 64'h0000_0005_0000_1111);
    wd_limit = 32'd20;
    idle(20);
    rd(3'd0, d, v); chk("R5 before expiry", d, 32'h0000_1111);
    rd(3'd0, d, v); chk("R5 after expiry", d, ONES);

    // R6 recovery, with a late sync in between (R5)
    drive(1'b1, 1'b1, 1'b1, 64'hAAAA);
    rd(3'd0, d, v); chk("R6 lone sync", d, ONES);
    idle(25);
    drive(1'b1, 1'b1, 1'b1, 64'hBBBB);
    rd(3'd0, d, v); chk("R5 late sync keeps fault", d, ONES);
    idle(5);
    drive(1'b1, 1'b1, 1'b1, 64'h0000_0009_0000_CCCC);
    rd(3'd0, d, v); chk("R6 recovered lo", d, 32'h0000_CCCC);
    rd(3'd1, d, v); chk("R6 recovered hi", d, 32'h0000_0009);

    // R4 processing disable for one cycle
    proc_en = 1'b0;
    idle(1);
    proc_en = 1'b1;
    rd(3'd0, d, v); chk("R4 disabled", d, ONES);
    drive(1'b1, 1'b1, 1'b1, 64'hDDDD);
    rd(3'd1, d, v); chk("R6 lone sync after disable", d, ONES);
    idle(3);
    drive(1'b1, 1'b1, 1'b1, 64'hEEEE);
    rd(3'd0, d, v); chk("R6 recovered after disable", d, 32'h0000_EEEE);

    // R9 invalid sync cycles leave stored number in place
    drive(1'b0, 1'b1, 1'b1, 64'h1234);
    rd(3'd0, d, v); chk("R9 invalid sync ignored", d, 32'h0000_EEEE);

    done = 1'b1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule